// File: doc/BRIEF.md
# Per-Endpoint Error Isolation Controller

This block keeps error-containment state for a fixed set of partitionable endpoints (PEs) that sit behind one host-to-I/O bridge. Every processor MMIO load or store and every device DMA request arrives with a PE index that has already been decoded. The block decides in the same cycle whether the transaction goes on, is dropped, or is answered with all-ones read data, and whether a machine-check flag goes back to the requester. Failure reports from the fabric name one PE and carry a mask of further downstream PEs that are affected. An MMIO access that the downstream side flags as faulting counts as a failure of its own PE.

Each PE has an isolation-enable bit and two stop states, one for MMIO and one for DMA, which software releases separately. It also has a sticky failure flag and a reset output that software controls. While a PE is stopped with isolation enabled, the block imitates a master abort: loads return all-ones with no error, stores vanish, new DMA is refused, and completions of DMA already in flight still pass. Software reaches the per-PE registers through a simple write strobe and a combinational read port. The address is `{pe_index, select}`: select 0 is the command register, 1 is the control register and 2 is the status register.

Top module: `pe_isolation_ctrl`

## Requirements
- R1: After reset, every PE reads status 0x08 (isolation enabled, nothing stopped, no sticky failure, reset output low), `pe_rst` is all zero and `sys_err` is low. Status bits: 0 MMIO-stopped, 1 DMA-stopped, 2 failure seen, 3 isolation enabled, 4 reset output.
- R2: A failure on an isolation-enabled PE sets its MMIO-stopped, DMA-stopped and failure-seen bits together on the next clock edge, so the status reads 0x0F. Other PEs are not touched.
- R3: A fabric report with `fail_valid` stops the PE named by `fail_pe` and also every PE whose bit is set in `fail_mask`. Each of them enters both stop states.
- R4: When a PE is MMIO-stopped, or the access itself has `mmio_fault` set, the access is not forwarded. A load then gets `mmio_all_ones` and a store is dropped silently. When isolation is enabled, `mmio_mchk` stays low.
- R5: A failure on a PE whose isolation is disabled does not stop that PE, and `sys_err` pulses in the following cycle. A load to a disabled PE that is stopped or faulting returns all-ones and also raises `mmio_mchk`.
- R6: A new DMA request (`dma_cpl`=0, which includes MSI writes) from a DMA-stopped PE is dropped. A completion for an earlier request (`dma_cpl`=1) is always forwarded.
- R7: Writing code 2 to a PE's command register clears only its MMIO-stopped bit. Code 3 clears only its DMA-stopped bit. Any other code changes nothing, and no other PE is affected.
- R8: Control register bit 0 is the isolation enable and bit 1 is the reset request, and both read back. Setting bit 1 raises that PE's `pe_rst` after the write edge. Clearing bit 1 while the request is set clears both stop bits. `pe_rst` then stays high for exactly 16 more clock edges after the write edge and drops on the 16th. Other PEs are unaffected.
- R9: The failure-seen bit stays set until a status-register write has bit 2 set. Release commands and writes with bit 2 clear leave it set.
- R10: A failure on an isolation-enabled PE never raises `sys_err`.
- R11: A failure and a release command that reach the same PE in the same cycle leave the PE stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_valid | input | 1 | MMIO access present |
| mmio_load | input | 1 | 1 = load, 0 = store |
| mmio_pe | input | 3 | Target PE of the MMIO access |
| mmio_fault | input | 1 | Downstream reports this access failed |
| mmio_fwd | output | 1 | Forward MMIO access downstream |
| mmio_all_ones | output | 1 | Answer the load with all-ones data |
| mmio_mchk | output | 1 | Machine-check indication to requester |
| dma_valid | input | 1 | DMA transaction present |
| dma_pe | input | 3 | Source PE of the DMA transaction |
| dma_cpl | input | 1 | 1 = completion of an earlier request |
| dma_fwd | output | 1 | Forward DMA transaction |
| dma_drop | output | 1 | DMA transaction discarded |
| fail_valid | input | 1 | Fabric failure report |
| fail_pe | input | 3 | PE named by the failure report |
| fail_mask | input | 8 | Further affected downstream PEs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | {PE index, select} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pe_rst | output | 8 | Per-PE reset outputs |
| sys_err | output | 1 | Uncontained failure, one-cycle pulse |

## Verification
The filtering decision is exercised with loads and stores to stopped PEs, to running PEs and to running PEs whose access faults. This separates a failure raised by the access itself from one recorded earlier. The same patterns are repeated on PEs with isolation disabled, both a PE that was never stopped and one stopped before it was disabled, so that the machine-check and `sys_err` paths are told apart from the contained case. DMA is tried with new requests and with completions on stopped and running PEs. Stop states are entered by a single-PE report, by a masked multi-PE report and by a faulting access. They are left through each release code, an unknown code, reset deassertion and a release that collides with a failure. For the reset hold, the output is sampled on every edge up to and including the one where it drops.

// File: rtl/pe_iso_pkg.sv
package pe_iso_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CODE_REL_MMIO = 2;
  localparam int unsigned CODE_REL_DMA  = 3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RST_BIT = 1;
  localparam int STAT_CLR_BIT = 2;

  // Packed status word: first field is the most significant bit (bit 4).
  typedef struct packed {
    logic rst_out;
    logic iso_en;
    logic fail_seen;
    logic dma_stop;
    logic mmio_stop;
  } pe_stat_t;

  localparam int STAT_W = $bits(pe_stat_t);

endpackage

// File: rtl/pe_slot.sv
module pe_slot
  import pe_iso_pkg::*;
#(
  parameter int RST_HOLD = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fail_evt,
  input  logic     rel_mmio,
  input  logic     rel_dma,
  input  logic     ctrl_wr,
  input  logic     ctrl_en_val,
  input  logic     ctrl_rst_val,
  input  logic     clr_fail,
  output pe_stat_t stat_o,
  output logic     rst_req_o,
  output logic     uncontained_o
);

  localparam int CNT_W = $clog2(RST_HOLD + 1);

  logic             iso_en;
  logic             mmio_stop;
  logic             dma_stop;
  logic             fail_seen;
  logic             rst_req;
  logic [CNT_W-1:0] hold_cnt;

  // Named events, shared by the state logic and the assertions
  logic contained_fail;
  logic deassert_evt;

  assign contained_fail = fail_evt & iso_en;
  assign uncontained_o  = fail_evt & ~iso_en;
  assign deassert_evt   = ctrl_wr & ~ctrl_rst_val & rst_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_en    <= 1'b1;
      mmio_stop <= 1'b0;
      dma_stop  <= 1'b0;
      fail_seen <= 1'b0;
      rst_req   <= 1'b0;
      hold_cnt  <= '0;
    end else begin
      if (ctrl_wr) begin
        iso_en  <= ctrl_en_val;
        rst_req <= ctrl_rst_val;
      end
      // A failure outranks any release arriving in the same cycle
      if (contained_fail)               mmio_stop <= 1'b1;
      else if (rel_mmio | deassert_evt) mmio_stop <= 1'b0;
      if (contained_fail)               dma_stop  <= 1'b1;
      else if (rel_dma | deassert_evt)  dma_stop  <= 1'b0;
      if (contained_fail)               fail_seen <= 1'b1;
      else if (clr_fail)                fail_seen <= 1'b0;
      if (deassert_evt)                 hold_cnt  <= CNT_W'(RST_HOLD);
      else if (hold_cnt != '0)          hold_cnt  <= hold_cnt - 1'b1;
    end
  end

  assign rst_req_o        = rst_req;
  assign stat_o.rst_out   = rst_req | (hold_cnt != '0);
  assign stat_o.iso_en    = iso_en;
  assign stat_o.fail_seen = fail_seen;
  assign stat_o.dma_stop  = dma_stop;
  assign stat_o.mmio_stop = mmio_stop;

  // R2: contained failure sets all three bits on the next edge
  a_r2_fail_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    contained_fail |=> (mmio_stop && dma_stop && fail_seen));

  // R5: a disabled PE that was running stays running after a failure
  a_r5_disabled_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt && !iso_en && !mmio_stop && !dma_stop) |=> (!mmio_stop && !dma_stop));

  // R8: reset deassertion clears both stop states
  a_r8_deassert_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (deassert_evt && !fail_evt) |=> (!mmio_stop && !dma_stop));

  // R8: the reset output is still high right after the deassert edge
  a_r8_hold_starts: assert property (@(posedge clk) disable iff (!rst_n)
    deassert_evt |=> stat_o.rst_out);

  // R9: sticky flag survives until write-one-to-clear
  a_r9_sticky_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_seen && !clr_fail) |=> fail_seen);

endmodule

// File: rtl/pe_reg_decode.sv
module pe_reg_decode
  import pe_iso_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 8,
  localparam int PE_W   = $clog2(NUM_PE),
  localparam int ADDR_W = PE_W + 2
) (
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  pe_stat_t [NUM_PE-1:0] stat_i,
  input  logic [NUM_PE-1:0]     rst_req_i,
  output logic [NUM_PE-1:0]     rel_mmio_o,
  output logic [NUM_PE-1:0]     rel_dma_o,
  output logic [NUM_PE-1:0]     ctrl_wr_o,
  output logic [NUM_PE-1:0]     clr_fail_o,
  output logic                  ctrl_en_val_o,
  output logic                  ctrl_rst_val_o,
  output logic [DATA_W-1:0]     reg_rdata
);

  function automatic logic [PE_W-1:0] addr_pe(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

  function automatic reg_sel_e addr_sel(input logic [ADDR_W-1:0] a);
    return reg_sel_e'(a[1:0]);
  endfunction

  function automatic logic is_code(input logic [DATA_W-1:0] d, input int unsigned code);
    return d == DATA_W'(code);
  endfunction

  logic [PE_W-1:0] tgt_pe;
  reg_sel_e        tgt_sel;

  assign tgt_pe         = addr_pe(reg_addr);
  assign tgt_sel        = addr_sel(reg_addr);
  assign ctrl_en_val_o  = reg_wdata[CTRL_EN_BIT];
  assign ctrl_rst_val_o = reg_wdata[CTRL_RST_BIT];

  for (genvar i = 0; i < NUM_PE; i++) begin : g_strobe
    logic hit;
    assign hit           = reg_wr && (tgt_pe == PE_W'(i));
    assign rel_mmio_o[i] = hit && (tgt_sel == SEL_CMD) && is_code(reg_wdata, CODE_REL_MMIO);
    assign rel_dma_o[i]  = hit && (tgt_sel == SEL_CMD) && is_code(reg_wdata, CODE_REL_DMA);
    assign ctrl_wr_o[i]  = hit && (tgt_sel == SEL_CTRL);
    assign clr_fail_o[i] = hit && (tgt_sel == SEL_STAT) && reg_wdata[STAT_CLR_BIT];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (tgt_sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_EN_BIT]  = stat_i[tgt_pe].iso_en;
        reg_rdata[CTRL_RST_BIT] = rst_req_i[tgt_pe];
      end
      SEL_STAT: reg_rdata[STAT_W-1:0] = stat_i[tgt_pe];
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pe_path_filter.sv
module pe_path_filter #(
  parameter int NUM_PE = 8,
  localparam int PE_W  = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmio_valid,
  input  logic              mmio_load,
  input  logic [PE_W-1:0]   mmio_pe,
  input  logic              mmio_fault,
  input  logic              dma_valid,
  input  logic [PE_W-1:0]   dma_pe,
  input  logic              dma_cpl,
  input  logic [NUM_PE-1:0] mmio_stop_vec,
  input  logic [NUM_PE-1:0] dma_stop_vec,
  input  logic [NUM_PE-1:0] iso_en_vec,
  output logic              mmio_fwd,
  output logic              mmio_all_ones,
  output logic              mmio_mchk,
  output logic              dma_fwd,
  output logic              dma_drop,
  output logic [NUM_PE-1:0] mmio_fail_vec
);

  logic mmio_blocked;
  logic dma_blocked;

  assign mmio_blocked  = mmio_stop_vec[mmio_pe] | mmio_fault;
  assign mmio_fwd      = mmio_valid & ~mmio_blocked;
  assign mmio_all_ones = mmio_valid & mmio_load & mmio_blocked;
  assign mmio_mchk     = mmio_all_ones & ~iso_en_vec[mmio_pe];

  assign dma_blocked   = ~dma_cpl & dma_stop_vec[dma_pe];
  assign dma_fwd       = dma_valid & ~dma_blocked;
  assign dma_drop      = dma_valid & dma_blocked;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_mfail
    assign mmio_fail_vec[i] = mmio_valid & mmio_fault & (mmio_pe == PE_W'(i));
  end

  // R4: a stopped PE never sees an MMIO access
  a_r4_stopped_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && mmio_stop_vec[mmio_pe]) |-> !mmio_fwd);

  // R4: contained PEs never raise machine check
  a_r4_contained_no_mchk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && iso_en_vec[mmio_pe]) |-> !mmio_mchk);

  // R6: completions always pass
  a_r6_cpl_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_cpl) |-> dma_fwd);

  // R6: new DMA from a DMA-stopped PE is refused
  a_r6_new_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_cpl && dma_stop_vec[dma_pe]) |-> (!dma_fwd && dma_drop));

endmodule

// File: rtl/pe_isolation_ctrl.sv
module pe_isolation_ctrl
  import pe_iso_pkg::*;
#(
  parameter int NUM_PE   = 8,
  parameter int RST_HOLD = 16,
  parameter int DATA_W   = 8,
  localparam int PE_W    = $clog2(NUM_PE),
  localparam int ADDR_W  = PE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmio_valid,
  input  logic              mmio_load,
  input  logic [PE_W-1:0]   mmio_pe,
  input  logic              mmio_fault,
  output logic              mmio_fwd,
  output logic              mmio_all_ones,
  output logic              mmio_mchk,
  input  logic              dma_valid,
  input  logic [PE_W-1:0]   dma_pe,
  input  logic              dma_cpl,
  output logic              dma_fwd,
  output logic              dma_drop,
  input  logic              fail_valid,
  input  logic [PE_W-1:0]   fail_pe,
  input  logic [NUM_PE-1:0] fail_mask,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_PE-1:0] pe_rst,
  output logic              sys_err
);

  function automatic logic [NUM_PE-1:0] fabric_hits(
    input logic              vld,
    input logic [PE_W-1:0]   pe,
    input logic [NUM_PE-1:0] mask
  );
    logic [NUM_PE-1:0] v;
    v = '0;
    if (vld) begin
      v     = mask;
      v[pe] = 1'b1;
    end
    return v;
  endfunction

  pe_stat_t [NUM_PE-1:0] stat;
  logic [NUM_PE-1:0] rst_req;
  logic [NUM_PE-1:0] uncontained_vec;
  logic [NUM_PE-1:0] fail_vec;
  logic [NUM_PE-1:0] mmio_fail_vec;
  logic [NUM_PE-1:0] rel_mmio, rel_dma, ctrl_wr, clr_fail;
  logic [NUM_PE-1:0] mmio_stop_vec, dma_stop_vec, iso_en_vec;
  logic              ctrl_en_val, ctrl_rst_val;
  logic              any_uncontained;

  assign fail_vec        = fabric_hits(fail_valid, fail_pe, fail_mask) | mmio_fail_vec;
  assign any_uncontained = |uncontained_vec;

  pe_reg_decode #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_decode (
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .stat_i         (stat),
    .rst_req_i      (rst_req),
    .rel_mmio_o     (rel_mmio),
    .rel_dma_o      (rel_dma),
    .ctrl_wr_o      (ctrl_wr),
    .clr_fail_o     (clr_fail),
    .ctrl_en_val_o  (ctrl_en_val),
    .ctrl_rst_val_o (ctrl_rst_val),
    .reg_rdata      (reg_rdata)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    pe_slot #(.RST_HOLD(RST_HOLD)) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .fail_evt      (fail_vec[i]),
      .rel_mmio      (rel_mmio[i]),
      .rel_dma       (rel_dma[i]),
      .ctrl_wr       (ctrl_wr[i]),
      .ctrl_en_val   (ctrl_en_val),
      .ctrl_rst_val  (ctrl_rst_val),
      .clr_fail      (clr_fail[i]),
      .stat_o        (stat[i]),
      .rst_req_o     (rst_req[i]),
      .uncontained_o (uncontained_vec[i])
    );
    assign mmio_stop_vec[i] = stat[i].mmio_stop;
    assign dma_stop_vec[i]  = stat[i].dma_stop;
    assign iso_en_vec[i]    = stat[i].iso_en;
    assign pe_rst[i]        = stat[i].rst_out;
  end

  pe_path_filter #(.NUM_PE(NUM_PE)) u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .mmio_valid    (mmio_valid),
    .mmio_load     (mmio_load),
    .mmio_pe       (mmio_pe),
    .mmio_fault    (mmio_fault),
    .dma_valid     (dma_valid),
    .dma_pe        (dma_pe),
    .dma_cpl       (dma_cpl),
    .mmio_stop_vec (mmio_stop_vec),
    .dma_stop_vec  (dma_stop_vec),
    .iso_en_vec    (iso_en_vec),
    .mmio_fwd      (mmio_fwd),
    .mmio_all_ones (mmio_all_ones),
    .mmio_mchk     (mmio_mchk),
    .dma_fwd       (dma_fwd),
    .dma_drop      (dma_drop),
    .mmio_fail_vec (mmio_fail_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sys_err <= 1'b0;
    else        sys_err <= any_uncontained;
  end

  // R10: upward error only follows a failure on a disabled PE
  a_r10_syserr_source: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> $past(any_uncontained));

  // R3: every PE hit by a masked report is stopped on the next edge if enabled
  a_r3_mask_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && ((fail_mask & iso_en_vec) != '0))
      |=> ((($past(fail_mask & iso_en_vec)) & ~(mmio_stop_vec & dma_stop_vec)) == '0));

endmodule

// File: tb/test_pe_isolation_ctrl.sv
module test_pe_isolation_ctrl;

  localparam int NUM_PE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mmio_valid = 0, mmio_load = 0, mmio_fault = 0;
  logic [2:0] mmio_pe = 0;
  logic       mmio_fwd, mmio_all_ones, mmio_mchk;
  logic       dma_valid = 0, dma_cpl = 0;
  logic [2:0] dma_pe = 0;
  logic       dma_fwd, dma_drop;
  logic       fail_valid = 0;
  logic [2:0] fail_pe = 0;
  logic [7:0] fail_mask = 0;
  logic       reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [7:0] pe_rst;
  logic       sys_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pe_isolation_ctrl i_pe_isolation_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mmio_valid(mmio_valid), .mmio_load(mmio_load), .mmio_pe(mmio_pe), .mmio_fault(mmio_fault),
    .mmio_fwd(mmio_fwd), .mmio_all_ones(mmio_all_ones), .mmio_mchk(mmio_mchk),
    .dma_valid(dma_valid), .dma_pe(dma_pe), .dma_cpl(dma_cpl),
    .dma_fwd(dma_fwd), .dma_drop(dma_drop),
    .fail_valid(fail_valid), .fail_pe(fail_pe), .fail_mask(fail_mask),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pe_rst(pe_rst), .sys_err(sys_err)
  );

  // Status word: {rst_out, iso_en, fail_seen, dma_stop, mmio_stop}
  localparam logic [7:0] ST_IDLE    = 8'h08;
  localparam logic [7:0] ST_STOPPED = 8'h0F;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int pe, input int sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = {3'(pe), 2'(sel)}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic reg_read(input int pe, input int sel, output logic [7:0] d);
    reg_addr = {3'(pe), 2'(sel)};
    #1;
    d = reg_rdata;
  endtask

  task automatic stat_is(input string req, input int pe, input logic [7:0] exp);
    logic [7:0] d;
    reg_read(pe, 2, d);
    chk(req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic fail_report(input int pe, input logic [7:0] mask);
    @(negedge clk);
    fail_valid = 1; fail_pe = 3'(pe); fail_mask = mask;
    @(negedge clk);
    fail_valid = 0; fail_mask = 0;
  endtask

  task automatic clean_all();
    for (int p = 0; p < NUM_PE; p++) begin
      reg_write(p, 1, 8'h01);
      reg_write(p, 0, 8'd2);
      reg_write(p, 0, 8'd3);
      reg_write(p, 2, 8'h04);
    end
  endtask

  task automatic t_reset_state();
    for (int p = 0; p < NUM_PE; p++) stat_is("R1 status after reset", p, ST_IDLE);
    chk("R1 pe_rst after reset", {24'd0, pe_rst}, 0);
    chk("R1 sys_err after reset", {31'd0, sys_err}, 0);
  endtask

  task automatic t_single_fail();
    fail_report(2, 8'h00);
    chk("R10 no sys_err for contained failure", {31'd0, sys_err}, 0);
    stat_is("R2 failing PE stopped", 2, ST_STOPPED);
    stat_is("R2 neighbour untouched", 1, ST_IDLE);
    clean_all();
  endtask

  task automatic t_mask_fail();
    fail_report(0, 8'b1010_0000);
    stat_is("R3 named PE0 stopped", 0, ST_STOPPED);
    stat_is("R3 mask PE5 stopped", 5, ST_STOPPED);
    stat_is("R3 mask PE7 stopped", 7, ST_STOPPED);
    stat_is("R3 PE6 outside mask", 6, ST_IDLE);
    clean_all();
  endtask

  task automatic t_mmio();
    fail_report(4, 8'h00);
    @(negedge clk);
    mmio_valid = 1; mmio_load = 1; mmio_pe = 4; #1;
    chk("R4 load to stopped not forwarded", {31'd0, mmio_fwd}, 0);
    chk("R4 load to stopped all-ones", {31'd0, mmio_all_ones}, 1);
    chk("R4 load to stopped no mchk", {31'd0, mmio_mchk}, 0);
    mmio_load = 0; #1;
    chk("R4 store to stopped dropped", {31'd0, mmio_fwd}, 0);
    chk("R4 store gives no read data", {31'd0, mmio_all_ones}, 0);
    mmio_load = 1; mmio_pe = 3; #1;
    chk("R4 load to running PE forwarded", {31'd0, mmio_fwd}, 1);
    chk("R4 load to running PE normal data", {31'd0, mmio_all_ones}, 0);
    mmio_fault = 1; #1;
    chk("R4 faulting load not forwarded", {31'd0, mmio_fwd}, 0);
    chk("R4 faulting load all-ones", {31'd0, mmio_all_ones}, 1);
    chk("R4 faulting load no mchk", {31'd0, mmio_mchk}, 0);
    @(negedge clk);
    mmio_valid = 0; mmio_fault = 0;
    stat_is("R2 faulting access stops its PE", 3, ST_STOPPED);
    clean_all();
  endtask

  task automatic t_disabled();
    reg_write(5, 1, 8'h00);
    fail_report(5, 8'h00);
    chk("R5 sys_err after disabled failure", {31'd0, sys_err}, 1);
    stat_is("R5 disabled PE not stopped", 5, 8'h00);
    @(negedge clk);
    chk("R5 sys_err is one pulse", {31'd0, sys_err}, 0);
    fail_report(6, 8'h00);
    reg_write(6, 1, 8'h00);
    @(negedge clk);
    mmio_valid = 1; mmio_load = 1; mmio_pe = 6; #1;
    chk("R5 stopped disabled load all-ones", {31'd0, mmio_all_ones}, 1);
    chk("R5 stopped disabled load mchk", {31'd0, mmio_mchk}, 1);
    chk("R5 stopped disabled load not forwarded", {31'd0, mmio_fwd}, 0);
    @(negedge clk);
    mmio_valid = 0;
    clean_all();
  endtask

  task automatic t_dma();
    fail_report(1, 8'h00);
    @(negedge clk);
    dma_valid = 1; dma_pe = 1; dma_cpl = 0; #1;
    chk("R6 new DMA from stopped dropped", {31'd0, dma_fwd}, 0);
    chk("R6 new DMA drop flag", {31'd0, dma_drop}, 1);
    dma_cpl = 1; #1;
    chk("R6 completion from stopped passes", {31'd0, dma_fwd}, 1);
    chk("R6 completion not dropped", {31'd0, dma_drop}, 0);
    dma_cpl = 0; dma_pe = 0; #1;
    chk("R6 new DMA from running PE passes", {31'd0, dma_fwd}, 1);
    @(negedge clk);
    dma_valid = 0;
  endtask

  task automatic t_release();
    // PE1 is still stopped from t_dma
    fail_report(4, 8'h00);
    reg_write(1, 0, 8'd3);
    stat_is("R7 code 3 clears DMA stop only", 1, 8'h0D);
    @(negedge clk);
    dma_valid = 1; dma_pe = 1; dma_cpl = 0; #1;
    chk("R7 DMA resumes after release", {31'd0, dma_fwd}, 1);
    @(negedge clk);
    dma_valid = 0;
    reg_write(4, 0, 8'd5);
    stat_is("R7 unknown code ignored", 4, ST_STOPPED);
    reg_write(1, 0, 8'd2);
    stat_is("R7 code 2 clears MMIO stop", 1, 8'h0C);
    stat_is("R7 other PE keeps stop", 4, ST_STOPPED);
  endtask

  task automatic t_sticky();
    reg_write(1, 2, 8'h03);
    stat_is("R9 write without bit 2 keeps sticky", 1, 8'h0C);
    reg_write(1, 2, 8'h04);
    stat_is("R9 write-one clears sticky", 1, ST_IDLE);
    clean_all();
  endtask

  task automatic t_reset_ctrl();
    logic [7:0] d;
    reg_write(3, 1, 8'h03);
    chk("R8 reset asserts only PE3", {24'd0, pe_rst}, 32'h08);
    reg_read(3, 1, d);
    chk("R8 control read-back", {24'd0, d}, 32'h03);
    fail_report(3, 8'h00);
    stat_is("R8 stopped while in reset", 3, 8'h1F);
    reg_write(3, 1, 8'h01);
    stat_is("R8 deassert clears stops", 3, 8'h1C);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      chk($sformatf("R8 reset held edge %0d", k), {31'd0, pe_rst[3]}, 1);
    end
    @(negedge clk);
    chk("R8 reset drops after hold", {24'd0, pe_rst}, 0);
    clean_all();
  endtask

  task automatic t_priority();
    @(negedge clk);
    fail_valid = 1; fail_pe = 2; fail_mask = 0;
    reg_wr = 1; reg_addr = {3'd2, 2'd0}; reg_wdata = 8'd2;
    @(negedge clk);
    fail_valid = 0; reg_wr = 0; reg_wdata = 0;
    stat_is("R11 failure beats release", 2, ST_STOPPED);
    clean_all();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_single_fail();
    t_mask_fail();
    t_mmio();
    t_disabled();
    t_dma();
    t_release();
    t_sticky();
    t_reset_ctrl();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule